// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block repairs a byte after two packed-BCD operands have been added in binary, so that the byte again holds two legal decimal digits. It takes the raw sum byte, the carry flag and the half-carry flag left by the addition. It returns the corrected byte and the updated carry flag. No other flag is read or written.

The correction has two steps. In the first step, 06h is added to the whole byte whenever the low digit is out of range or the half carry is set. A carry out of that add ripples through the upper digit. The second step then adds 60h whenever the upper digit is out of range or the carry is set. Either step may set the carry flag, but neither step ever clears it.

With the default parameter, the result is captured in registers on each cycle in which `valid_in` is high. It appears on the outputs one clock later. With `REG_OUT = 0`, the outputs follow the inputs combinationally within the same cycle.

Top module: `bcd_adjust`

## Requirements
- R1: When the low digit (bits 3:0) is greater than 9 or `ac_in` is 1, 06h is added to the full 8-bit byte, so a carry out of bit 3 propagates into bits 7:4 (for example, 9Ah with both flags clear gives 00h with carry 1).
- R2: A carry out of bit 7 from the 06h correction sets `cy_out` (for example, FAh with both flags clear gives 60h with carry 1).
- R3: After the first step, when the upper digit (bits 7:4) is greater than 9 or the carry is 1, 60h is added; a carry out of bit 7 sets `cy_out` (BEh gives 24h with carry 1, and C9h gives 29h with carry 1).
- R4: `cy_out` is never cleared by the adjustment: `cy_in` = 1 always yields `cy_out` = 1, and `cy_out` = 0 only when no step produced a carry.
- R5: The difference `acc_out - acc_in` modulo 256 is always one of 00h, 06h, 60h or 66h.
- R6: In registered mode, `acc_out`, `cy_out` and `valid_out` = 1 appear on the clock edge after the edge that samples `valid_in` = 1; `valid_out` is 0 one edge after `valid_in` is sampled 0.
- R7: In registered mode, a cycle with `valid_in` = 0 leaves `acc_out` and `cy_out` unchanged, whatever `acc_in`, `cy_in` and `ac_in` carry.
- R8: A synchronous active-high `rst` sets `acc_out` to 00h and clears `cy_out` and `valid_out` on the next clock edge.
- R9: For BCD operands x and y (each 0..99) and a carry-in c, the adjusted binary sum of x + y + c (with its half carry and carry) is the decimal value (x+y+c) mod 100, with `cy_out` = 1 exactly when x+y+c ≥ 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input byte and flags are valid this cycle |
| acc_in | input | 8 | Raw binary sum byte |
| cy_in | input | 1 | Carry flag from the addition |
| ac_in | input | 1 | Half-carry flag from the addition (carry out of bit 3) |
| acc_out | output | 8 | Decimal-adjusted byte |
| cy_out | output | 1 | Updated carry flag |
| valid_out | output | 1 | Output byte and flag are valid |

## Verification
In the default registered configuration, every result is due exactly one clock edge after the edge that samples it. The bench therefore drives each vector on a falling edge and compares on the next falling edge, which lies half a period after the capturing rising edge. The sweep covers all 256 byte values under every combination of the two flags, against a reference computed arithmetically in the bench. A run of random decimal additions then confirms R9. Directed idle cycles with changing inputs check that the outputs hold.

// File: rtl/bcd_adjust_pkg.sv
package bcd_adjust_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam logic [NIB_W-1:0] DIGIT_MAX = 4'd9;
  localparam logic [BYTE_W:0]  FIX_LO = 9'h006;
  localparam logic [BYTE_W:0]  FIX_HI = 9'h060;

  typedef struct packed {
    logic              cy;
    logic [BYTE_W-1:0] val;
  } adj_word_t;
endpackage

// File: rtl/bcd_lo_fix.sv
module bcd_lo_fix
  import bcd_adjust_pkg::*;
(
  input  adj_word_t word_i,
  input  logic      ac_i,
  output adj_word_t word_o
);
  logic            need_fix;
  logic [BYTE_W:0] sum;

  always_comb begin
    need_fix   = (word_i.val[NIB_W-1:0] > DIGIT_MAX) || ac_i;
    // full-width add: a low carry ripples through the upper digit
    sum        = {1'b0, word_i.val} + (need_fix ? FIX_LO : '0);
    word_o.val = sum[BYTE_W-1:0];
    word_o.cy  = word_i.cy | sum[BYTE_W];
  end
endmodule

// File: rtl/bcd_hi_fix.sv
module bcd_hi_fix
  import bcd_adjust_pkg::*;
(
  input  adj_word_t word_i,
  output adj_word_t word_o
);
  logic            need_fix;
  logic [BYTE_W:0] sum;

  always_comb begin
    need_fix   = (word_i.val[BYTE_W-1:NIB_W] > DIGIT_MAX) || word_i.cy;
    sum        = {1'b0, word_i.val} + (need_fix ? FIX_HI : '0);
    word_o.val = sum[BYTE_W-1:0];
    word_o.cy  = word_i.cy | sum[BYTE_W];
  end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import bcd_adjust_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [BYTE_W-1:0] acc_in,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic [BYTE_W-1:0] acc_out,
  output logic              cy_out,
  output logic              valid_out
);
  adj_word_t raw_w, mid_w, fin_w;

  assign raw_w.val = acc_in;
  assign raw_w.cy  = cy_in;

  bcd_lo_fix u_lo (.word_i(raw_w), .ac_i(ac_in), .word_o(mid_w));
  bcd_hi_fix u_hi (.word_i(mid_w), .word_o(fin_w));

  generate
    if (REG_OUT) begin : g_reg
      adj_word_t         out_q;
      logic              vld_q;
      logic [BYTE_W-1:0] seen_q;
      logic [BYTE_W-1:0] delta;

      always_ff @(posedge clk) begin
        if (rst) begin
          out_q  <= '0;
          vld_q  <= 1'b0;
          seen_q <= '0;
        end else begin
          vld_q <= valid_in;
          if (valid_in) begin
            out_q  <= fin_w;
            seen_q <= acc_in;
          end
        end
      end

      assign acc_out   = out_q.val;
      assign cy_out    = out_q.cy;
      assign valid_out = vld_q;
      assign delta     = out_q.val - seen_q;

      a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
      a_r6_idle_latency: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
      a_r4_carry_kept: assert property (@(posedge clk) disable iff (rst)
        (valid_in && cy_in) |=> cy_out);
      a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(acc_out) && $stable(cy_out)));
      a_r5_fix_set: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> (delta == 8'h00 || delta == 8'h06 ||
                       delta == 8'h60 || delta == 8'h66));
      a_r8_reset: assert property (@(posedge clk)
        rst |=> (!valid_out && !cy_out && acc_out == '0));
    end else begin : g_comb
      assign acc_out   = fin_w.val;
      assign cy_out    = fin_w.cy;
      assign valid_out = valid_in;
    end
  endgenerate
endmodule

// File: tb/bcd_adjust_tb_top.sv
module bcd_adjust_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       valid_in;
  logic [7:0] acc_in;
  logic       cy_in;
  logic       ac_in;
  logic [7:0] acc_out;
  logic       cy_out;
  logic       valid_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adjust #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .acc_in(acc_in),
    .cy_in(cy_in), .ac_in(ac_in), .acc_out(acc_out), .cy_out(cy_out),
    .valid_out(valid_out));

  function automatic int ref_adj(int a, int c, int h);
    int v = a;
    int k = c;
    if ((a % 16) > 9 || h != 0) v = v + 6;
    if (v > 255) begin k = 1; v = v - 256; end
    if ((v / 16) > 9 || k != 0) v = v + 96;
    if (v > 255) begin k = 1; v = v - 256; end
    return k * 256 + v;
  endfunction

  function automatic int to_bcd(int d);
    return (d / 10) * 16 + (d % 10);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic apply(int a, int c, int h);
    @(negedge clk);
    valid_in = 1'b1;
    acc_in   = 8'(a);
    cy_in    = c[0];
    ac_in    = h[0];
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; valid_in = 1'b0; acc_in = 8'h5A; cy_in = 1'b1; ac_in = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset clears all outputs
    check("R8 acc", int'(acc_out), 0);
    check("R8 cy", int'(cy_out), 0);
    check("R8 valid", int'(valid_out), 0);
    rst = 1'b0;

    // directed corners
    apply(8'hBE, 0, 0); check("R3 BE", {cy_out, acc_out}, 9'h124);
    apply(8'hC9, 0, 0); check("R3 C9", {cy_out, acc_out}, 9'h129);
    apply(8'hFA, 0, 0); check("R2 FA", {cy_out, acc_out}, 9'h160);
    apply(8'h9A, 0, 0); check("R1 9A", {cy_out, acc_out}, 9'h100);
    apply(8'h12, 1, 0); check("R4 12", {cy_out, acc_out}, 9'h172);
    check("R6 valid", int'(valid_out), 1);

    // R7: idle cycles with moving inputs leave outputs untouched
    @(negedge clk);
    valid_in = 1'b0; acc_in = 8'hFF; cy_in = 1'b0; ac_in = 1'b1;
    @(negedge clk);
    check("R7 acc", int'(acc_out), 8'h72);
    check("R7 cy", int'(cy_out), 1);
    check("R6 idle", int'(valid_out), 0);
    acc_in = 8'h00; cy_in = 1'b1;
    @(negedge clk);
    check("R7 acc2", int'(acc_out), 8'h72);

    // exhaustive sweep: 256 bytes x 4 flag pairs
    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < 256; a++) begin
        int e;
        int d;
        string tag;
        e = ref_adj(a, f / 2, f % 2);
        apply(a, f / 2, f % 2);
        if (f / 2 == 1)                       tag = "R4";
        else if ((a % 16) > 9 || f % 2 == 1)  tag = "R1";
        else                                  tag = "R3";
        check(tag, {cy_out, acc_out}, e);
        d = (int'(acc_out) - a + 256) % 256;
        check("R5", int'(d == 0 || d == 6 || d == 96 || d == 102), 1);
      end
    end

    // R9: random decimal additions
    for (int t = 0; t < 200; t++) begin
      int x, y, c, bin, hc, s;
      x   = int'($urandom_range(99, 0));
      y   = int'($urandom_range(99, 0));
      c   = int'($urandom_range(1, 0));
      bin = to_bcd(x) + to_bcd(y) + c;
      hc  = ((to_bcd(x) % 16) + (to_bcd(y) % 16) + c) > 15 ? 1 : 0;
      s   = x + y + c;
      apply(bin % 256, bin > 255 ? 1 : 0, hc);
      check("R9 sum", int'(acc_out), to_bcd(s % 100));
      check("R9 carry", int'(cy_out), s >= 100 ? 1 : 0);
    end

    @(negedge clk);
    valid_in = 1'b0;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule